// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core together with its 8-bit status register. A five-bit mode field in the status register selects the active processor mode. Part of the register space is physically replicated per mode, so an exception handler gets private working registers without saving anything to memory. Logical registers 0–7 and 15 exist once. Registers 8–12 have one copy reserved for fast-interrupt mode and one copy shared by every other mode. Registers 13–14 have six copies: one shared by user and system mode, and one for each of the five exception modes.

The core reads two logical registers combinationally and writes one per clock. All three ports translate the logical number through the mode currently held in the status register. A separate debug port takes an explicit mode and register number, so any physical copy can be inspected without switching modes. The status register is written as a whole. A write that carries an unknown mode code is dropped, and a one-cycle flag reports it.

Top module: `bank_regfile`

## Requirements
- R1: After reset, status reads 0xD3: supervisor mode, both interrupt-disable bits set, the compact-instruction bit clear. `privileged` is 1, `illegalMode` is 0, and every physical register reads zero.
- R2: Logical registers 0–7 have one copy. A value written in any mode reads back identically in all seven modes.
- R3: Logical registers 8–12 have two copies. Fast-interrupt mode (0x11) uses one copy. All other modes share the second copy.
- R4: Logical registers 13–14 have six copies. User (0x10) and system (0x1F) modes share one copy. Supervisor (0x13), abort (0x17), undefined (0x1B), interrupt (0x12) and fast-interrupt (0x11) modes each own one copy.
- R5: Logical register 15 has one copy, shared by all modes.
- R6: A status write whose bits 4:0 hold one of the seven legal mode codes replaces all eight status bits at the next clock edge. The bit layout is: bit 7 disables normal interrupts, bit 6 disables fast interrupts, bit 5 selects the compact instruction set, and bits 4:0 hold the mode.
- R7: A status write whose mode code is not legal leaves the whole status register unchanged. `illegalMode` is then high for exactly the one cycle after that clock edge.
- R8: Both read ports are combinational and translate through the mode held in the status register.
- R9: If a register write and a status write occur in the same cycle, the register write lands in the bank of the mode held before the status change.
- R10: The debug port returns the copy selected by `dbgMode` and `dbgAddr`. It returns zero when `dbgMode` is not a legal mode code.
- R11: `privileged` is 0 exactly when the held mode is user mode (0x10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 4 | Read port A logical register |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B logical register |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write logical number |
| wrData | input | 32 | Register write data |
| statWrEn | input | 1 | Status write enable |
| statWrData | input | 8 | New status value |
| statusOut | output | 8 | Current status register |
| privileged | output | 1 | High in every mode except user |
| illegalMode | output | 1 | One-cycle pulse after a rejected status write |
| dbgMode | input | 5 | Debug port mode |
| dbgAddr | input | 4 | Debug port logical register |
| dbgData | output | 32 | Debug port data |

## Verification
A wrong bank mapping stays silent until the affected copy is read through the mode that owns it. The debug port makes that visible in the same cycle, without a mode change: sweeping all seven modes across all sixteen registers exposes a misrouted write at once. A corrupted status register shows on `statusOut` one clock after the write. A write that went through the new mode instead of the old one shows up as a missing value in the old mode's copy of register 13.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int REG_ADDR_W = 4;
  localparam int MODE_W = 5;
  localparam int STAT_W = 8;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  localparam int ST_IRQ_OFF = 7;
  localparam int ST_FIQ_OFF = 6;
  localparam int ST_COMPACT = 5;
  localparam logic [STAT_W-1:0] STATUS_RESET = {1'b1, 1'b1, 1'b0, MODE_SVC};

  // Logical register classes
  localparam int SHARED_CNT = 8;                       // r0..r7
  localparam int FIQ_BANKED_CNT = 5;                   // r8..r12
  localparam int STACK_BANKS = 6;                      // banks for r13/r14
  localparam int STACK_REGS = 2;                       // r13, r14
  localparam int FIRST_STACK = SHARED_CNT + FIQ_BANKED_CNT;
  localparam int PC_LOG = FIRST_STACK + STACK_REGS;

  // Physical layout
  localparam int PHYS_FIQ_BASE = SHARED_CNT + FIQ_BANKED_CNT;
  localparam int PHYS_STACK_BASE = PHYS_FIQ_BASE + FIQ_BANKED_CNT;
  localparam int PHYS_PC = PHYS_STACK_BASE + STACK_BANKS * STACK_REGS;
  localparam int NUM_PHYS = PHYS_PC + 1;
  localparam int PHYS_W = $clog2(NUM_PHYS);

  typedef struct packed {
    logic regWe;
    logic [MODE_W-1:0] wrMode;
    logic [MODE_W-1:0] rdMode;
  } ctrlStrobe_t;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int stackBank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_SVC: return 1;
      MODE_ABT: return 2;
      MODE_UND: return 3;
      MODE_IRQ: return 4;
      MODE_FIQ: return 5;
      default:  return 0;   // user and system
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] physIdx(input logic [MODE_W-1:0] m,
                                                 input logic [REG_ADDR_W-1:0] r);
    int ri;
    int res;
    ri = int'(r);
    if (ri < SHARED_CNT) res = ri;
    else if (ri < FIRST_STACK) res = (m == MODE_FIQ) ? ri + FIQ_BANKED_CNT : ri;
    else if (ri < PC_LOG) res = PHYS_STACK_BASE + stackBank(m) * STACK_REGS + (ri - FIRST_STACK);
    else res = PHYS_PC;
    return PHYS_W'(res);
  endfunction
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              statWrEn,
  input  logic [STAT_W-1:0] statWrData,
  output logic [STAT_W-1:0] status,
  output logic              illegalMode,
  output logic              privileged,
  output ctrlStrobe_t       strobe
);
  logic wrLegal;
  assign wrLegal = modeLegal(statWrData[MODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= STATUS_RESET;
      illegalMode <= 1'b0;
    end else begin
      illegalMode <= statWrEn && !wrLegal;
      if (statWrEn && wrLegal) status <= statWrData;
    end
  end

  // register writes use the mode held now, before any same-cycle change
  always_comb begin
    strobe.regWe = wrEn;
    strobe.wrMode = status[MODE_W-1:0];
    strobe.rdMode = status[MODE_W-1:0];
  end

  assign privileged = (status[MODE_W-1:0] != MODE_USR);

  // R6
  legal_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn && modeLegal(statWrData[MODE_W-1:0])) |=> (status == $past(statWrData)));
  // R7
  reject_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn && !modeLegal(statWrData[MODE_W-1:0])) |=> (illegalMode && status == $past(status)));
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |=> (!illegalMode || $past(statWrEn)));
  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLegal(status[MODE_W-1:0]));
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [REG_ADDR_W-1:0] rdAddrA,
  input  logic [REG_ADDR_W-1:0] rdAddrB,
  input  logic [MODE_W-1:0]     dbgMode,
  input  logic [REG_ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0]     rdDataA,
  output logic [DATA_W-1:0]     rdDataB,
  output logic [DATA_W-1:0]     dbgData
);
  logic [DATA_W-1:0] phys [NUM_PHYS];
  logic [NUM_PHYS-1:0] weVec;
  logic [PHYS_W-1:0] wrIdx;

  assign wrIdx = physIdx(strobe.wrMode, wrAddr);

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_cell
    assign weVec[p] = strobe.regWe && (wrIdx == PHYS_W'(p));
    always_ff @(posedge clk) begin
      if (!rstN) phys[p] <= '0;
      else if (weVec[p]) phys[p] <= wrData;
    end
  end

  assign rdDataA = phys[physIdx(strobe.rdMode, rdAddrA)];
  assign rdDataB = phys[physIdx(strobe.rdMode, rdAddrB)];
  assign dbgData = modeLegal(dbgMode) ? phys[physIdx(dbgMode, dbgAddr)] : '0;

  // R2
  one_cell_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(weVec));
  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWe |=> (phys[$past(wrIdx)] == $past(wrData)));
  // R3
  fiq_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regWe && strobe.wrMode == MODE_FIQ && wrAddr == 4'd8) |=> $stable(phys[8]));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statWrEn,
  input  logic [7:0]        statWrData,
  output logic [7:0]        statusOut,
  output logic              privileged,
  output logic              illegalMode,
  input  logic [4:0]        dbgMode,
  input  logic [3:0]        dbgAddr,
  output logic [DATA_W-1:0] dbgData
);
  ctrlStrobe_t strobe;

  bank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .statWrEn(statWrEn), .statWrData(statWrData),
    .status(statusOut), .illegalMode(illegalMode),
    .privileged(privileged), .strobe(strobe)
  );

  bank_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .dbgMode(dbgMode), .dbgAddr(dbgAddr),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .dbgData(dbgData)
  );

  // R11
  user_unpriv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn && statWrData[4:0] == MODE_USR) |=> !privileged);
endmodule

// File: tb/tb_bank_regfile.sv
module tb_bank_regfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0, dbgAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, dbgData;
  logic wrEn = 1'b0, statWrEn = 1'b0;
  logic [7:0] statWrData = '0, statusOut;
  logic privileged, illegalMode;
  logic [4:0] dbgMode = 5'h13;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  bank_regfile dut (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statWrEn(statWrEn), .statWrData(statWrData),
    .statusOut(statusOut), .privileged(privileged), .illegalMode(illegalMode),
    .dbgMode(dbgMode), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  typedef struct packed {
    logic [4:0]  mode;
    logic [3:0]  rn;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{5'h13, 4'd0,  32'hA000_0000},
    '{5'h11, 4'd0,  32'hA000_0001},
    '{5'h10, 4'd8,  32'hB000_0008},
    '{5'h11, 4'd8,  32'hF000_0008},
    '{5'h12, 4'd12, 32'hB000_000C},
    '{5'h11, 4'd12, 32'hF000_000C},
    '{5'h1F, 4'd13, 32'h5000_0013},
    '{5'h10, 4'd14, 32'h5000_000E},
    '{5'h13, 4'd13, 32'hC000_0013},
    '{5'h17, 4'd13, 32'hA000_0013},
    '{5'h1B, 4'd14, 32'hD000_000E},
    '{5'h12, 4'd13, 32'hE000_0013},
    '{5'h11, 4'd14, 32'hF000_000E},
    '{5'h1B, 4'd15, 32'h0000_1000},
    '{5'h13, 4'd7,  32'h7777_7777}
  };

  localparam logic [4:0] MODES [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  logic [31:0] expMem [7][16];

  function automatic logic [4:0] grp(input logic [4:0] m);
    return (m == 5'h1F) ? 5'h10 : m;
  endfunction

  function automatic bit sameBank(input logic [4:0] a, input logic [4:0] b, input int r);
    if (r < 8 || r == 15) return 1'b1;
    if (r < 13) return (a == 5'h11) == (b == 5'h11);
    return grp(a) == grp(b);
  endfunction

  function automatic string tagOf(input int r);
    if (r < 8) return "R2";
    if (r < 13) return "R3";
    if (r < 15) return "R4";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [4:0] m, input int r, input logic [31:0] v);
    for (int k = 0; k < 7; k++)
      if (sameBank(m, MODES[k], r)) expMem[k][r] = v;
  endtask

  task automatic setStatus(input logic [7:0] v);
    @(negedge clk);
    statWrEn = 1'b1; statWrData = v;
    @(negedge clk);
    statWrEn = 1'b0;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sweep(input bit atReset);
    for (int k = 0; k < 7; k++)
      for (int r = 0; r < 16; r++) begin
        dbgMode = MODES[k]; dbgAddr = 4'(r);
        #1;
        check(atReset ? "R1 zero" : {tagOf(r), " R10 bank"}, dbgData, expMem[k][r]);
      end
  endtask

  initial begin
    for (int k = 0; k < 7; k++)
      for (int r = 0; r < 16; r++) expMem[k][r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 status", {24'd0, statusOut}, 32'hD3);
    check("R1 privileged", {31'd0, privileged}, 32'd1);
    check("R1 illegalMode", {31'd0, illegalMode}, 32'd0);
    sweep(1'b1);

    // table walk: set mode, write, read back on port A (R6, R8)
    for (int i = 0; i < NV; i++) begin
      setStatus({3'b110, VECS[i].mode});
      check("R6 status", {24'd0, statusOut}, {24'd0, 3'b110, VECS[i].mode});
      writeReg(VECS[i].rn, VECS[i].val);
      modelWrite(VECS[i].mode, int'(VECS[i].rn), VECS[i].val);
      rdAddrA = VECS[i].rn;
      #1;
      check("R8 port A", rdDataA, VECS[i].val);
    end
    sweep(1'b0);

    // R8: both ports in fast-interrupt mode
    setStatus(8'hD1);
    rdAddrA = 4'd8; rdAddrB = 4'd13;
    #1;
    check("R8 port A fiq r8", rdDataA, 32'hF000_0008);
    check("R8 port B fiq r13", rdDataB, expMem[1][13]);

    // R6: all status bits replaced
    setStatus(8'h3F);
    check("R6 full byte", {24'd0, statusOut}, 32'h3F);

    // R11 privilege
    check("R11 system priv", {31'd0, privileged}, 32'd1);
    setStatus(8'hD0);
    check("R11 user unpriv", {31'd0, privileged}, 32'd0);

    // R7 illegal mode write
    setStatus(8'h1A);
    check("R7 status kept", {24'd0, statusOut}, 32'hD0);
    check("R7 pulse high", {31'd0, illegalMode}, 32'd1);
    @(negedge clk);
    check("R7 pulse low", {31'd0, illegalMode}, 32'd0);
    setStatus(8'h00);
    check("R7 status kept zero code", {24'd0, statusOut}, 32'hD0);

    // R9 simultaneous register write and mode change
    setStatus(8'hD3);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'h0000_0099;
    statWrEn = 1'b1; statWrData = 8'hD2;
    @(negedge clk);
    wrEn = 1'b0; statWrEn = 1'b0;
    modelWrite(5'h13, 13, 32'h0000_0099);
    check("R9 status", {24'd0, statusOut}, 32'hD2);
    dbgMode = 5'h13; dbgAddr = 4'd13; #1;
    check("R9 old mode bank", dbgData, 32'h0000_0099);
    dbgMode = 5'h12; #1;
    check("R9 new mode untouched", dbgData, 32'hE000_0013);

    // R10 illegal debug mode reads zero
    dbgMode = 5'h14; dbgAddr = 4'd0; #1;
    check("R10 illegal dbg mode", dbgData, 32'd0);
    sweep(1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule